// File: doc/BRIEF.md
# PCM Bit-Clock and Frame-Sync Generator

This block produces the serial bit clock and the frame-sync pulse for a PCM audio port that runs as clock master. Two source clocks reach it as single-cycle enables in one system clock domain. A select bit in a clock-control word chooses between them. The selected tick drives a half-period divider, which toggles the bit clock, and a frame counter, which marks the first bit of every sample frame.

The clock-control word comes from a register outside the block. It carries an enable bit, the source select, a serial-clock divider and a frame-length divider. The serial clock runs only when the enable bit is set and either the port is enabled or the continuous-clock policy is chosen. When it stops, the bit clock parks low and every counter clears, so the next start begins with a full frame. Divider updates written while the clock runs are held in shadow registers and applied at the next frame start. This avoids a short or a stretched frame.

With the default 9-bit dividers, the bit-clock period is 2×(clock divider+1) source ticks. A target rate therefore needs a clock divider of src/(frame_len×fs)/2−1. The frame length is the frame divider plus one, and the usual setting is 127 for 128 bit clocks per frame.

Top module: `pcm_clkgen`

## Requirements
- R1: Bit 2·DIV_W of `clkctl_i` (bit 18 by default) selects the source tick: 1 takes `per_tick_i` and 0 takes `alt_tick_i`.
- R2: The clock divider occupies bits [2·DIV_W−1:DIV_W] of `clkctl_i` ([17:9] by default). Each bit-clock half-period lasts that value plus one selected ticks, so consecutive rising edges lie 2×(div+1) ticks apart.
- R3: `bclk_rise_o` is high for exactly the one cycle in which `bclk_o` has just become 1, and `bclk_fall_o` for the one cycle in which it has just become 0 while running. The two strobes are never high together. A falling edge follows its rising edge by div+1 ticks.
- R4: The frame divider occupies bits [DIV_W−1:0] of `clkctl_i`. A frame spans that value plus one bit clocks.
- R5: `fsync_o` rises together with the first rising bit-clock edge of each frame and changes only on rising edges, so it stays high for one bit-clock period. With a one-bit-clock frame it stays high.
- R6: The serial clock runs only when bit 2·DIV_W+1 of `clkctl_i` (bit 19 by default) is set and `port_en_i` or `idle_clk_i` is 1. In every cycle after this condition is false, `bclk_o`, `fsync_o` and both strobes are 0.
- R7: After the clock starts, the first rising edge comes div+1 ticks later and carries `fsync_o`, so the first frame has full length.
- R8: Divider values changed while running take effect from the next frame start. The current frame keeps its old bit period and length.
- R9: During reset and after it, all outputs are 0.
- R10: In a cycle with no selected tick, `bclk_o` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| per_tick_i | input | 1 | Peripheral source clock enable |
| alt_tick_i | input | 1 | Alternate audio source clock enable |
| port_en_i | input | 1 | PCM port enable |
| idle_clk_i | input | 1 | 1: keep the bit clock running while the port is idle |
| clkctl_i | input | 2·DIV_W+2 | Clock-control word: enable, select, clock divider, frame divider |
| bclk_o | output | 1 | Bit-clock level |
| bclk_rise_o | output | 1 | Rising-edge strobe |
| bclk_fall_o | output | 1 | Falling-edge strobe |
| fsync_o | output | 1 | Frame-sync pulse |

## Verification
The bench builds the block with DIV_W=4. Both dividers can then be swept exhaustively over all 256 pairs, each for two complete frames from a fresh start. This covers the one-tick half-period and the one-bit-clock frame at the lower edges, and the largest counts at the upper edges. Directed runs with a sparse alternate tick, with a starved source, with the gating inputs toggled, and with a divider rewrite in the middle of a frame cover source selection, clock holding, parking and the deferred update.

// File: rtl/pcm_clkgen_pkg.sv
package pcm_clkgen_pkg;
  typedef enum logic {
    SRC_ALT = 1'b0,
    SRC_PER = 1'b1
  } src_sel_e;

  localparam int unsigned DEF_DIV_W = 9;
endpackage

// File: rtl/pcm_src_sel.sv
module pcm_src_sel
  import pcm_clkgen_pkg::*;
(
  input  src_sel_e sel_i,
  input  logic     per_tick_i,
  input  logic     alt_tick_i,
  output logic     tick_o
);
  always_comb begin
    unique case (sel_i)
      SRC_PER: tick_o = per_tick_i;
      default: tick_o = alt_tick_i;
    endcase
  end
endmodule

// File: rtl/pcm_bclk_div.sv
module pcm_bclk_div #(
  parameter int unsigned DIV_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] half_div_i,
  output logic             bclk_o,
  output logic             rise_o,
  output logic             fall_o,
  output logic             rise_nx_o
);
  logic [DIV_W-1:0] half_cnt_q;
  logic             bclk_q, rise_q, fall_q;
  logic             toggle, fall_nx;

  always_comb begin
    toggle    = run_i & tick_i & (half_cnt_q >= half_div_i);
    rise_nx_o = toggle & ~bclk_q;
    fall_nx   = toggle & bclk_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_cnt_q <= '0;
      bclk_q     <= 1'b0;
      rise_q     <= 1'b0;
      fall_q     <= 1'b0;
    end else if (!run_i) begin
      half_cnt_q <= '0;
      bclk_q     <= 1'b0;
      rise_q     <= 1'b0;
      fall_q     <= 1'b0;
    end else begin
      rise_q <= rise_nx_o;
      fall_q <= fall_nx;
      if (tick_i) begin
        half_cnt_q <= toggle ? '0 : half_cnt_q + 1'b1;
        if (toggle) bclk_q <= ~bclk_q;
      end
    end
  end

  assign bclk_o = bclk_q;
  assign rise_o = rise_q;
  assign fall_o = fall_q;
endmodule

// File: rtl/pcm_frame_ctr.sv
module pcm_frame_ctr #(
  parameter int unsigned DIV_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             rise_nx_i,
  input  logic [DIV_W-1:0] frame_div_i,
  output logic             fsync_o,
  output logic             frame_start_nx_o
);
  logic [DIV_W-1:0] bit_idx_q;
  logic             started_q, fsync_q;

  // a frame opens on the first rising edge after start or after the last bit
  assign frame_start_nx_o = rise_nx_i & (~started_q | (bit_idx_q >= frame_div_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_idx_q <= '0;
      started_q <= 1'b0;
      fsync_q   <= 1'b0;
    end else if (!run_i) begin
      bit_idx_q <= '0;
      started_q <= 1'b0;
      fsync_q   <= 1'b0;
    end else if (rise_nx_i) begin
      started_q <= 1'b1;
      fsync_q   <= frame_start_nx_o;
      bit_idx_q <= frame_start_nx_o ? '0 : bit_idx_q + 1'b1;
    end
  end

  assign fsync_o = fsync_q;
endmodule

// File: rtl/pcm_clkgen.sv
module pcm_clkgen
  import pcm_clkgen_pkg::*;
#(
  parameter int unsigned DIV_W = DEF_DIV_W,
  localparam int unsigned CTL_W = 2 * DIV_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             per_tick_i,
  input  logic             alt_tick_i,
  input  logic             port_en_i,
  input  logic             idle_clk_i,
  input  logic [CTL_W-1:0] clkctl_i,
  output logic             bclk_o,
  output logic             bclk_rise_o,
  output logic             bclk_fall_o,
  output logic             fsync_o
);
  localparam int unsigned SEL_BIT = 2 * DIV_W;
  localparam int unsigned EN_BIT  = 2 * DIV_W + 1;

  logic             run, tick, rise_nx, frame_start_nx;
  src_sel_e         src_sel;
  logic [DIV_W-1:0] half_sh_q, frame_sh_q;

  assign run     = clkctl_i[EN_BIT] & (port_en_i | idle_clk_i);
  assign src_sel = src_sel_e'(clkctl_i[SEL_BIT]);

  // shadow dividers follow the word while stopped, reload only at frame start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_sh_q  <= '0;
      frame_sh_q <= '0;
    end else if (!run || frame_start_nx) begin
      half_sh_q  <= clkctl_i[2*DIV_W-1:DIV_W];
      frame_sh_q <= clkctl_i[DIV_W-1:0];
    end
  end

  pcm_src_sel u_src (
    .sel_i      (src_sel),
    .per_tick_i (per_tick_i),
    .alt_tick_i (alt_tick_i),
    .tick_o     (tick)
  );

  pcm_bclk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .tick_i     (tick),
    .half_div_i (half_sh_q),
    .bclk_o     (bclk_o),
    .rise_o     (bclk_rise_o),
    .fall_o     (bclk_fall_o),
    .rise_nx_o  (rise_nx)
  );

  pcm_frame_ctr #(.DIV_W(DIV_W)) u_frm (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .run_i            (run),
    .rise_nx_i        (rise_nx),
    .frame_div_i      (frame_sh_q),
    .fsync_o          (fsync_o),
    .frame_start_nx_o (frame_start_nx)
  );
endmodule

// File: rtl/pcm_clkgen_chk.sv
module pcm_clkgen_chk #(
  parameter int unsigned DIV_W = 9,
  localparam int unsigned CTL_W = 2 * DIV_W + 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             per_tick_i,
  input logic             alt_tick_i,
  input logic             port_en_i,
  input logic             idle_clk_i,
  input logic [CTL_W-1:0] clkctl_i,
  input logic             bclk_o,
  input logic             bclk_rise_o,
  input logic             bclk_fall_o,
  input logic             fsync_o
);
  logic run_c, tick_c;
  assign run_c  = clkctl_i[2*DIV_W+1] & (port_en_i | idle_clk_i);
  assign tick_c = clkctl_i[2*DIV_W] ? per_tick_i : alt_tick_i;

  AST_RISE_IS_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bclk_rise_o |-> (bclk_o && !$past(bclk_o)));  // R3
  AST_FALL_IS_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bclk_fall_o |-> (!bclk_o && $past(bclk_o)));  // R3
  AST_FALL_STROBED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(bclk_o) && $past(run_c)) |-> bclk_fall_o);  // R3
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bclk_rise_o && bclk_fall_o));  // R3
  AST_IDLE_PARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_c |=> (!bclk_o && !fsync_o && !bclk_rise_o && !bclk_fall_o));  // R6
  AST_FSYNC_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((fsync_o != $past(fsync_o)) && $past(run_c)) |-> bclk_rise_o);  // R5
  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_c && !tick_c) |=> $stable(bclk_o));  // R10
endmodule

bind pcm_clkgen pcm_clkgen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .per_tick_i  (per_tick_i),
  .alt_tick_i  (alt_tick_i),
  .port_en_i   (port_en_i),
  .idle_clk_i  (idle_clk_i),
  .clkctl_i    (clkctl_i),
  .bclk_o      (bclk_o),
  .bclk_rise_o (bclk_rise_o),
  .bclk_fall_o (bclk_fall_o),
  .fsync_o     (fsync_o)
);

// File: tb/sim_pcm_clkgen.sv
module sim_pcm_clkgen;
  localparam int W = 4;
  localparam int CW = 2 * W + 2;
  localparam time T_CLK = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic per_en, alt_en, port_en, idle_clk;
  logic [CW-1:0] clkctl;
  logic bclk, rise, fall, fsync;

  int errs = 0, checks = 0, stepn = 0, alt_per = 0;
  bit done = 0;

  always #(T_CLK/2) clk = ~clk;

  pcm_clkgen #(.DIV_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .per_tick_i(per_en), .alt_tick_i(alt_en),
    .port_en_i(port_en), .idle_clk_i(idle_clk), .clkctl_i(clkctl),
    .bclk_o(bclk), .bclk_rise_o(rise), .bclk_fall_o(fall), .fsync_o(fsync)
  );

  function automatic logic [CW-1:0] mk(bit en, bit sel, int d, int s);
    mk = {en, sel, 4'(d), 4'(s)};
  endfunction

  task automatic step();
    @(negedge clk);
    stepn++;
    alt_en = (alt_per > 0) && ((stepn % alt_per) == 0);
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // fresh start with per tick every cycle; two full frames
  task automatic sweep_one(int d, int s);
    int n = 0, last = 0, first = -1, t = 0, bad = 0;
    int target = 2 * (s + 1) + 1;
    int limit = (target + 2) * 2 * (d + 1) + 8;
    bit e_per = 0, e_fs = 0, e_edge = 0;
    clkctl = mk(0, 1, d, s);
    step(); step();
    chk(!bclk && !fsync && !rise, "R6 stopped", int'(bclk), 0);
    clkctl = mk(1, 1, d, s);
    while (n < target && t < limit) begin
      step(); t++;
      if (rise) begin
        if (!bclk) e_edge = 1;
        if (n == 0) first = t;
        else if (t - last != 2 * (d + 1)) begin e_per = 1; bad = t - last; end
        if (fsync != ((n % (s + 1)) == 0)) e_fs = 1;
        last = t; n++;
      end
      if (fall && (bclk || (t - last != d + 1))) e_edge = 1;
    end
    chk(first == d + 1 && n > 0, "R7 first edge", first, d + 1);
    chk(!e_per, "R2 period", bad, 2 * (d + 1));
    chk(!e_fs, "R4 R5 frame", int'(e_fs), 0);
    chk(!e_edge, "R3 strobes", int'(e_edge), 0);
    chk(n == target, "R2 rise count", n, target);
  endtask

  task automatic count_rises(int cyc, output int nr);
    nr = 0;
    for (int i = 0; i < cyc; i++) begin step(); if (rise) nr++; end
  endtask

  // interval between rises 2..5 after start
  task automatic src_test(bit sel, int exp_int);
    int n = 0, last = 0, t = 0;
    bit bad = 0;
    int got = 0;
    clkctl = mk(0, sel, 1, 2); step(); step();
    clkctl = mk(1, sel, 1, 2);
    while (n < 6 && t < 400) begin
      step(); t++;
      if (rise) begin
        if (n >= 2 && t - last != exp_int) begin bad = 1; got = t - last; end
        last = t; n++;
      end
    end
    chk(!bad && n == 6, "R1 source select", got, exp_int);
  endtask

  initial begin
    int nr;
    per_en = 1'b1; alt_en = 1'b0; port_en = 1'b1; idle_clk = 1'b0;
    clkctl = mk(0, 1, 0, 0);
    repeat (3) @(negedge clk);
    chk(!bclk && !rise && !fall && !fsync, "R9 in reset", int'(bclk | fsync), 0);
    rst_n = 1'b1;
    step(); step();
    chk(!bclk && !rise && !fall && !fsync, "R9 after reset", int'(bclk | fsync), 0);

    for (int d = 0; d < 16; d++)
      for (int s = 0; s < 16; s++)
        sweep_one(d, s);

    // R1: alt tick every third cycle vs per tick every cycle
    alt_per = 3;
    src_test(1'b0, 12);
    src_test(1'b1, 4);

    // R10: selected source starved
    alt_per = 0;
    clkctl = mk(0, 0, 0, 3); step();
    clkctl = mk(1, 0, 0, 3);
    begin
      bit moved = 0;
      for (int i = 0; i < 30; i++) begin step(); if (bclk || rise || fall) moved = 1; end
      chk(!moved, "R10 no tick hold", int'(moved), 0);
    end

    // R6 gating
    clkctl = mk(1, 1, 1, 3); port_en = 1'b0; idle_clk = 1'b0;
    begin
      bit seen = 0;
      for (int i = 0; i < 40; i++) begin step(); if (bclk || rise || fsync) seen = 1; end
      chk(!seen, "R6 port off gated", int'(seen), 0);
    end
    idle_clk = 1'b1;
    count_rises(40, nr);
    chk(nr == 10, "R6 idle clock runs", nr, 10);
    port_en = 1'b1; idle_clk = 1'b0;
    count_rises(40, nr);
    chk(nr == 10, "R6 port on runs", nr, 10);
    clkctl = mk(0, 1, 1, 3);
    begin
      bit seen = 0;
      for (int i = 0; i < 20; i++) begin step(); if (bclk || rise || fall || fsync) seen = 1; end
      chk(!seen, "R6 enable bit off", int'(seen), 0);
    end

    // R8: change dividers after second rise of the first frame
    begin
      int n = 0, last = 0, t = 0;
      bit e_int = 0, e_fs = 0;
      clkctl = mk(1, 1, 1, 3);
      while (n < 14 && t < 300) begin
        step(); t++;
        if (rise) begin
          if (n >= 1 && n <= 4 && t - last != 4) e_int = 1;
          if (n >= 5 && t - last != 6) e_int = 1;
          if (fsync != (n == 0 || n == 4 || n == 10)) e_fs = 1;
          last = t; n++;
          if (n == 2) clkctl = mk(1, 1, 2, 5);
        end
      end
      chk(!e_int && n == 14, "R8 period switch at frame", n, 14);
      chk(!e_fs, "R8 frame length switch", int'(e_fs), 0);
    end

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errs++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule